// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is a bit-level master for a single-wire, open-drain serial bus. Software reaches it through a small set of byte-wide registers. It programs a clock divider so that a prescaler produces a tick of about one microsecond. It then starts one bus operation at a time by writing a control bit, and polls that bit until it clears. Three operations exist: a bus reset with presence detection, a time slot that writes a zero, and a time slot that writes a one and samples the line as a read bit.

The bus side has two pins. One is a drive-low enable that pulls the shared line to ground. The other is the line input, which passes through a two-flop synchronizer before it is sampled. The block never drives the line high. Byte transfers and device searches are left to software, which builds them from single slots. A completion flag with an enable bit gives a simple interrupt request.

Top module: `owm_master`

## Requirements
- R1: The divider register at offset 0x02 reads back the last value written. Offsets 0x04, 0x06 and 0x08 always read 0x00, and writes to them change nothing.
- R2: With divider value D, the tick period is N = D+1 clock cycles, and every slot and reset duration below is a tick count times N. Writing the divider restarts the prescaler, so no tick occurs in the cycle after a write of a nonzero value.
- R3: Writing control (offset 0x00) with bit 7 set while idle starts a reset. The drive-low enable is asserted for 480·N cycles, and bit 7 reads 1 for 960·N cycles and then clears.
- R4: In a reset, the synchronized line is sampled 550·N cycles after the start. Control bit 6 then holds 1 if the line was low (a device answered) and 0 if it was high, until the next reset samples again.
- R5: Writing control bit 5 while idle starts a write-0 slot. The enable is asserted for 60·N cycles, and bit 5 reads 1 for 70·N cycles.
- R6: Writing control bit 4 while idle starts a write-1/read slot. The enable is asserted for 6·N cycles, the synchronized line is sampled at 15·N cycles into control bit 3, and bit 4 reads 1 for 70·N cycles.
- R7: A control write while an operation is running is ignored. The running operation's timing and its busy bit are unchanged.
- R8: When several command bits are written together, bit 7 wins over bit 5, and bit 5 wins over bit 4. Only the winning operation runs.
- R9: The drive-low enable is 0 whenever no operation is running. The line input reaches the sample points only through a two-flop synchronizer.
- R10: Bit 0 at offset 0x0A sets when any operation completes. Writing 1 to it clears it. If completion and a clear fall in the same cycle, the set wins.
- R11: Bit 0 at offset 0x0C is a read/write enable, and irq equals the completion flag AND that enable.
- R12: After reset, control reads 0x00, the divider reads 0x00, the completion flag and enable are 0, and the drive-low enable and irq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| busIn | input | 1 | Raw line level from the bus |
| busDriveLow | output | 1 | Open-drain pull-down enable |
| irq | output | 1 | Completion interrupt request |

## Verification
The bound checker checks several rules on every cycle. Operations begin only after a control write, and a write during a running operation never adds a busy bit. A divider write is never followed at once by a tick. The fall of the busy state always leaves the completion flag set, and irq never rises without its enable. The exact lengths of the drive-low windows, the sample points, the value captured for presence and for read bits, the command priority and the way durations scale with the divider are shown only by the bench. It compares every cycle against a behavioural timing model while a simulated device holds the line high or low.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RST  = 2'd1,
    OP_W0   = 2'd2,
    OP_W1R  = 2'd3
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic divLoad;
    logic capPresence;
    logic capRead;
  } dpStrobe_t;

  localparam int ADDR_CTRL    = 'h0;
  localparam int ADDR_DIV     = 'h2;
  localparam int ADDR_INTSTAT = 'hA;
  localparam int ADDR_INTEN   = 'hC;

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_INIT    = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DIV_W-1:0] divIn,
  input  logic             busIn,
  output logic             tick,
  output logic [CNT_W-1:0] usCount,
  output logic [DIV_W-1:0] divValue,
  output logic             presence,
  output logic             readBit
);

  logic [DIV_W-1:0]       prescCnt;
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineNow;

  assign lineNow  = syncReg[SYNC_STAGES-1];
  assign tick     = (prescCnt == divValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divValue <= DIV_W'(DIV_INIT);
      prescCnt <= '0;
      usCount  <= '0;
      syncReg  <= '1;
      presence <= 1'b0;
      readBit  <= 1'b0;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], busIn};

      if (strobe.divLoad) divValue <= divIn;

      if (strobe.divLoad || strobe.restart || tick) prescCnt <= '0;
      else                                         prescCnt <= prescCnt + 1'b1;

      if (strobe.restart)  usCount <= '0;
      else if (tick)       usCount <= usCount + 1'b1;

      if (strobe.capPresence) presence <= ~lineNow;
      if (strobe.capRead)     readBit  <= lineNow;
    end
  end

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 10,
  parameter int RST_LOW    = 480,
  parameter int RST_SAMPLE = 550,
  parameter int RST_END    = 960,
  parameter int W0_LOW     = 60,
  parameter int W0_END     = 70,
  parameter int W1_LOW     = 6,
  parameter int W1_SAMPLE  = 15,
  parameter int W1_END     = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              tick,
  input  logic [CNT_W-1:0]  usCount,
  input  logic [DIV_W-1:0]  divValue,
  input  logic              presence,
  input  logic              readBit,
  output dpStrobe_t         strobe,
  output logic              busDriveLow,
  output logic [7:0]        rdData,
  output logic              irq,
  output logic [2:0]        busyBits,
  output logic              intFlag,
  output logic              intEn
);

  opKind_t          op, startKind;
  logic [CNT_W-1:0] lowLim, endLim, sampLim;
  logic             ctrlWr, atEnd, sampleNow;

  assign ctrlWr = wrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    if (wrData[7])      startKind = OP_RST;
    else if (wrData[5]) startKind = OP_W0;
    else if (wrData[4]) startKind = OP_W1R;
    else                startKind = OP_IDLE;
  end

  always_comb begin
    unique case (op)
      OP_RST: begin
        lowLim = CNT_W'(RST_LOW); endLim = CNT_W'(RST_END - 1); sampLim = CNT_W'(RST_SAMPLE - 1);
      end
      OP_W0: begin
        lowLim = CNT_W'(W0_LOW); endLim = CNT_W'(W0_END - 1); sampLim = '0;
      end
      OP_W1R: begin
        lowLim = CNT_W'(W1_LOW); endLim = CNT_W'(W1_END - 1); sampLim = CNT_W'(W1_SAMPLE - 1);
      end
      default: begin
        lowLim = '0; endLim = '0; sampLim = '0;
      end
    endcase
  end

  assign atEnd     = (op != OP_IDLE) && tick && (usCount == endLim);
  assign sampleNow = tick && (usCount == sampLim);

  assign strobe.restart     = ctrlWr && (op == OP_IDLE) && (startKind != OP_IDLE);
  assign strobe.divLoad     = wrEn && (regAddr == ADDR_W'(ADDR_DIV));
  assign strobe.capPresence = sampleNow && (op == OP_RST);
  assign strobe.capRead     = sampleNow && (op == OP_W1R);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op      <= OP_IDLE;
      intFlag <= 1'b0;
      intEn   <= 1'b0;
    end else begin
      if (strobe.restart) op <= startKind;
      else if (atEnd)     op <= OP_IDLE;

      if (atEnd)
        intFlag <= 1'b1;
      else if (wrEn && (regAddr == ADDR_W'(ADDR_INTSTAT)) && wrData[0])
        intFlag <= 1'b0;

      if (wrEn && (regAddr == ADDR_W'(ADDR_INTEN))) intEn <= wrData[0];
    end
  end

  assign busyBits    = {op == OP_RST, op == OP_W0, op == OP_W1R};
  assign busDriveLow = (op != OP_IDLE) && (usCount < lowLim);
  assign irq         = intFlag && intEn;

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL))
      rdData = {busyBits[2], presence, busyBits[1], busyBits[0], readBit, 3'b000};
    else if (regAddr == ADDR_W'(ADDR_DIV))
      rdData = 8'(divValue);
    else if (regAddr == ADDR_W'(ADDR_INTSTAT))
      rdData = {7'b0, intFlag};
    else if (regAddr == ADDR_W'(ADDR_INTEN))
      rdData = {7'b0, intEn};
  end

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 0,
  parameter int RST_END  = 960,
  localparam int CNT_W   = $clog2(RST_END + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              busIn,
  output logic              busDriveLow,
  output logic              irq
);

  dpStrobe_t        strobe;
  logic             tick, presence, readBit, intFlag, intEn;
  logic [CNT_W-1:0] usCount;
  logic [DIV_W-1:0] divValue;
  logic [2:0]       busyBits;

  owm_datapath #(.DIV_W(DIV_W), .CNT_W(CNT_W), .SYNC_STAGES(2), .DIV_INIT(DIV_INIT)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divIn(DIV_W'(wrData)), .busIn(busIn),
    .tick(tick), .usCount(usCount), .divValue(divValue),
    .presence(presence), .readBit(readBit)
  );

  owm_control #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .RST_END(RST_END)) ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .tick(tick), .usCount(usCount), .divValue(divValue),
    .presence(presence), .readBit(readBit),
    .strobe(strobe), .busDriveLow(busDriveLow), .rdData(rdData), .irq(irq),
    .busyBits(busyBits), .intFlag(intFlag), .intEn(intEn)
  );

endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        wrData,
  input logic              tick,
  input logic [2:0]        busyBits,
  input logic              intFlag,
  input logic              intEn,
  input logic              irq
);

  AST_DIV_RESTARTS_PRESC: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(2) && wrData != 8'd0) |=> !tick); // R2

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|busyBits) |-> $past(wrEn && regAddr == ADDR_W'(0))); // R3

  AST_BUSY_NO_NEW_OP: assert property (@(posedge clk) disable iff (!rstN)
    ((|busyBits) && wrEn && regAddr == ADDR_W'(0)) |=> ((busyBits & ~$past(busyBits)) == 3'b000)); // R7

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|busyBits) |-> intFlag); // R10

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEn); // R11

endmodule

bind owm_master owm_master_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .tick(tick), .busyBits(busyBits), .intFlag(intFlag), .intEn(intEn), .irq(irq)
);

// File: tb/owm_master_test.sv
module owm_master_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       busIn, busDriveLow, irq;
  logic       devLow = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign busIn = !(busDriveLow || devLow);

  owm_master uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .busIn(busIn), .busDriveLow(busDriveLow), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int mOp = 0;   // 0 idle, 1 reset, 2 write-0, 3 write-1/read
  int k = 0;
  int mDiv = 0;
  bit mPres = 0, mRead = 0, mFlag = 0, mEn = 0;

  function automatic int lowTicks(int op);
    return (op == 1) ? 480 : (op == 2) ? 60 : (op == 3) ? 6 : 0;
  endfunction
  function automatic int endTicks(int op);
    return (op == 1) ? 960 : 70;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOp = 0; k = 0; mDiv = 0; mPres = 0; mRead = 0; mFlag = 0; mEn = 0;
    end else begin
      int n;
      n = mDiv + 1;
      if (wrEn && regAddr == 4'hA && wrData[0]) mFlag = 0;
      if (mOp != 0) begin
        k++;
        if (mOp == 1 && k == 550 * n) mPres = !busIn;
        if (mOp == 3 && k == 15 * n)  mRead = busIn;
        if (k == endTicks(mOp) * n) begin mOp = 0; mFlag = 1; end
      end else if (wrEn && regAddr == 4'h0) begin
        if (wrData[7])      mOp = 1;
        else if (wrData[5]) mOp = 2;
        else if (wrData[4]) mOp = 3;
        k = 0;
      end
      if (wrEn && regAddr == 4'h2) mDiv = wrData;
      if (wrEn && regAddr == 4'hC) mEn = wrData[0];
    end
  end

  function automatic logic [7:0] expRead(logic [3:0] a);
    case (a)
      4'h0: return {mOp == 1, mPres, mOp == 2, mOp == 3, mRead, 3'b000};
      4'h2: return 8'(mDiv);
      4'hA: return {7'b0, mFlag};
      4'hC: return {7'b0, mEn};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(int op);
    return (op == 1) ? "R3" : (op == 2) ? "R5" : (op == 3) ? "R6" : "R9";
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic expDrv;
      expDrv = (mOp != 0) && (k < lowTicks(mOp) * (mDiv + 1));
      checks++;
      if (busDriveLow !== expDrv) begin
        failures++;
        $display("FAIL %s drive actual=%0b expected=%0b", reqOf(mOp), busDriveLow, expDrv);
      end
      checks++;
      if (rdData !== expRead(regAddr)) begin
        failures++;
        $display("FAIL R1 rdData@%0h actual=%02h expected=%02h", regAddr, rdData, expRead(regAddr));
      end
      checks++;
      if (irq !== (mFlag && mEn)) begin
        failures++;
        $display("FAIL R11 irq actual=%0b expected=%0b", irq, mFlag && mEn);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; regAddr = 4'h0; wrData = 8'h00;
  endtask

  task automatic rdAt(input logic [3:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    v = rdData;
    @(posedge clk); #1;
    regAddr = 4'h0;
  endtask

  // waits until control busy bits clear; returns cycles with drive and busy
  task automatic runOp(input logic [7:0] cmd, output int lowCyc, output int busyCyc);
    lowCyc = 0; busyCyc = 0;
    wr(4'h0, cmd);
    @(negedge clk);
    while ((rdData & 8'hB0) != 0 && busyCyc < 50000) begin
      busyCyc++;
      if (busDriveLow) lowCyc++;
      @(negedge clk);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    int lowC, busyC;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(rdData == 8'h00, "R12 ctrl after reset", rdData, 0);
    check(busDriveLow == 1'b0 && irq == 1'b0, "R12 pins after reset", {busDriveLow, irq}, 0);
    rdAt(4'h2, v);  check(v == 8'h00, "R12 divider after reset", v, 0);
    rdAt(4'hA, v);  check(v == 8'h00, "R12 flag after reset", v, 0);

    // R1 register map
    wr(4'h2, 8'h01);
    rdAt(4'h2, v);  check(v == 8'h01, "R1 divider readback", v, 1);
    wr(4'h4, 8'hFF); wr(4'h6, 8'hFF); wr(4'h8, 8'hFF);
    rdAt(4'h4, v);  check(v == 8'h00, "R1 offset 4 reads zero", v, 0);
    rdAt(4'h6, v);  check(v == 8'h00, "R1 offset 6 reads zero", v, 0);
    rdAt(4'h8, v);  check(v == 8'h00, "R1 offset 8 reads zero", v, 0);
    rdAt(4'h2, v);  check(v == 8'h01, "R1 divider untouched", v, 1);

    // R11 enable, R5 write-0 with N=2
    wr(4'hC, 8'h01);
    runOp(8'h20, lowC, busyC);
    check(lowC == 120, "R5 write-0 low cycles", lowC, 120);
    check(busyC == 140, "R5 write-0 busy cycles", busyC, 140);
    check(irq == 1'b1, "R11 irq after completion", irq, 1);
    wr(4'hA, 8'h01);
    check(irq == 1'b0, "R10 flag cleared by write", irq, 0);

    // R6 write-1/read, line left high then held low by device
    devLow = 1'b0;
    runOp(8'h10, lowC, busyC);
    check(lowC == 12 && busyC == 140, "R6 write-1 timing", lowC * 1000 + busyC, 12140);
    check(rdData[3] == 1'b1, "R6 read bit high", rdData[3], 1);
    devLow = 1'b1;
    runOp(8'h10, lowC, busyC);
    devLow = 1'b0;
    check(rdData[3] == 1'b0, "R6 read bit low", rdData[3], 0);

    // R3/R4 reset with and without presence
    devLow = 1'b1;
    runOp(8'h80, lowC, busyC);
    devLow = 1'b0;
    check(busyC == 1920, "R3 reset busy cycles", busyC, 1920);
    check(rdData[6] == 1'b1, "R4 presence seen", rdData[6], 1);
    runOp(8'h80, lowC, busyC);
    check(lowC == 960, "R3 reset low cycles", lowC, 960);
    check(rdData[6] == 1'b0, "R4 no presence", rdData[6], 0);

    // R7 writes ignored while busy
    wr(4'h0, 8'h10);
    repeat (5) @(posedge clk);
    wr(4'h0, 8'hA0);
    @(negedge clk);
    check(rdData[7:4] == 4'b0001, "R7 busy write ignored", rdData[7:4], 1);
    while ((rdData & 8'hB0) != 0) @(negedge clk);
    check(busDriveLow == 1'b0, "R9 idle no drive", busDriveLow, 0);

    // R8 priority
    wr(4'h0, 8'hB0);
    @(negedge clk);
    check(rdData[7:4] == 4'b1000, "R8 reset wins", rdData[7:4], 8);
    while ((rdData & 8'hB0) != 0) @(negedge clk);
    wr(4'h0, 8'h30);
    @(negedge clk);
    check(rdData[7:4] == 4'b0010, "R8 write-0 beats write-1", rdData[7:4], 2);
    while ((rdData & 8'hB0) != 0) @(negedge clk);

    // R2 different divider
    wr(4'h2, 8'h03);
    runOp(8'h20, lowC, busyC);
    check(lowC == 240 && busyC == 280, "R2 scaled slot", lowC * 1000 + busyC, 240280);
    wr(4'hC, 8'h00);
    check(irq == 1'b0, "R11 irq masked", irq, 0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(10 * 200000);
    done = 1;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule